// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block is a first-in first-out buffer whose producer and consumer run on two unrelated clocks. Words are stored in a small dual-port register array: the producer writes it on its own clock and the consumer reads it combinationally on the other side. Each side keeps a local binary counter, one bit wider than the array address. The extra top bit marks wrap-around, and the remaining bits address the array. Each side also keeps a registered Gray-coded copy of that counter.

Only the Gray copies cross the clock boundary. Each passes as a whole word through a two-stage synchronizer into the opposite domain. The producer compares its next Gray pointer with the synchronized consumer pointer to raise `full`. The consumer compares its next Gray pointer with the synchronized producer pointer to raise `empty`. Both flags are registered on the same edge that moves the local pointer. A request that meets a raised flag is dropped and does not move any pointer.

The read data port always shows the word at the head of the queue. A consumer may take that word on any read-clock edge where `empty` is low and `rd_en` is high.

Top module: `dual_clock_fifo`

## Requirements
- R1: While either reset is held low, and at the first edge after it is released, `empty` reads 1 and `full` reads 0.
- R2: Words leave `rd_data` in exactly the order and with exactly the values they were accepted. A write is accepted on a `wclk` rising edge with `wr_en`=1 and `full`=0. A read is taken on an `rclk` rising edge with `rd_en`=1 and `empty`=0, and `rd_data` shows the head word before that edge.
- R3: A write request while `full`=1 is ignored: it stores nothing, it does not move the write pointer, and the queue contents read out afterwards are unchanged.
- R4: A read request while `empty`=1 is ignored: the read pointer does not move, and the next word written is the next word read.
- R5: After a write into an empty FIFO with reads idle, `empty` falls no later than the fourth `rclk` rising edge after that write edge. The nominal delay is three edges; the fourth allows for clock phase.
- R6: Once the read pointer has settled, `full` is 0 after DEPTH-1 writes and rises on the same `wclk` edge that accepts the DEPTH-th stored word.
- R7: Once the write pointer has settled, `empty` rises on the same `rclk` edge that takes the last stored word.
- R8: After a read from a full FIFO with writes idle, `full` falls no later than the fourth `wclk` rising edge after that read edge.
- R9: Data and ordering stay correct across many wraps of both pointers, with both ports active at once.
- R10: Each registered Gray pointer changes in at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Producer clock |
| wrst_n | input | 1 | Producer-side asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No free slot seen by the producer |
| rclk | input | 1 | Consumer clock |
| rrst_n | input | 1 | Consumer-side asynchronous reset, active low |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Head word of the queue |
| empty | output | 1 | No stored word seen by the consumer |

## Verification
A flag's own-domain reaction (R6, R7) is due at the very edge that moves the local pointer, so it is sampled at the falling edge that follows. A cross-domain reaction takes two synchronizer stages plus the flag register, which is three edges of the far clock. The bench counts far-clock edges after the stimulus and accepts a change up to the fourth edge (R5, R8). Elsewhere, before any exact comparison of the flags against the model's occupancy, it waits until both synchronizers have settled. Every accept decision, and every data compare at the head, is made at the falling edge before the rising edge it concerns, since the registered flags are stable there.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int PMAX = 32;
  typedef logic [PMAX-1:0] pword_t;

  // Binary to reflected Gray: neighbours differ in one bit.
  function automatic pword_t to_gray(input pword_t b);
    return b ^ (b >> 1);
  endfunction

  // Producer side: distance of one full lap means the top two Gray bits differ.
  function automatic logic lap_apart(input pword_t mine, input pword_t far, input int pw);
    pword_t flip;
    flip = pword_t'(3) << (pw - 2);
    return mine == (far ^ flip);
  endfunction

  // Consumer side: caught up when both Gray words match.
  function automatic logic caught_up(input pword_t mine, input pword_t far);
    return mine == far;
  endfunction
endpackage

// File: rtl/dcf_sync2.sv
module dcf_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/dcf_store.sv
module dcf_store #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int SLOTS = 1 << AW;
  logic [DW-1:0] cells [SLOTS];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dcf_ptr.sv
module dcf_ptr
  import dcf_pkg::*;
#(
  parameter int AW       = 3,
  parameter bit IS_WRITE = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [AW:0] far_gray,
  output logic [AW:0] bin,
  output logic [AW:0] gray,
  output logic        flag,
  output logic        fire
);
  localparam int  PW       = AW + 1;
  localparam logic FLAG_RST = IS_WRITE ? 1'b0 : 1'b1;

  logic [AW:0] bin_q, gray_q, bin_nx, gray_nx;
  logic        flag_q, flag_nx;

  assign fire    = req & ~flag_q;
  assign bin_nx  = bin_q + {{AW{1'b0}}, fire};
  assign gray_nx = PW'(to_gray(pword_t'(bin_nx)));

  generate
    if (IS_WRITE) begin : g_full
      assign flag_nx = lap_apart(pword_t'(gray_nx), pword_t'(far_gray), PW);
    end else begin : g_empty
      assign flag_nx = caught_up(pword_t'(gray_nx), pword_t'(far_gray));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
      flag_q <= FLAG_RST;
    end else begin
      bin_q  <= bin_nx;
      gray_q <= gray_nx;
      flag_q <= flag_nx;
    end
  end

  assign bin  = bin_q;
  assign gray = gray_q;
  assign flag = flag_q;
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty
);
  logic [ADDR_W:0] wbin, wgray, rbin, rgray;
  logic [ADDR_W:0] rgray_at_w, wgray_at_r;
  logic            wr_fire, rd_fire;

  dcf_ptr #(.AW(ADDR_W), .IS_WRITE(1'b1)) u_wptr (
    .clk(wclk), .rst_n(wrst_n), .req(wr_en), .far_gray(rgray_at_w),
    .bin(wbin), .gray(wgray), .flag(full), .fire(wr_fire)
  );

  dcf_ptr #(.AW(ADDR_W), .IS_WRITE(1'b0)) u_rptr (
    .clk(rclk), .rst_n(rrst_n), .req(rd_en), .far_gray(wgray_at_r),
    .bin(rbin), .gray(rgray), .flag(empty), .fire(rd_fire)
  );

  dcf_sync2 #(.W(ADDR_W + 1)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_at_w)
  );

  dcf_sync2 #(.W(ADDR_W + 1)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_at_r)
  );

  dcf_store #(.AW(ADDR_W), .DW(DATA_W)) u_store (
    .wclk(wclk), .we(wr_fire), .waddr(wbin[ADDR_W-1:0]), .wdata(wr_data),
    .raddr(rbin[ADDR_W-1:0]), .rdata(rd_data)
  );
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
  parameter int PW = 4
) (
  input logic          wclk,
  input logic          rclk,
  input logic          wrst_n,
  input logic          rrst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          full,
  input logic          empty,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] rbin
);
  // R10
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  // R10
  rgray_step_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray ^ $past(rgray)) <= 1);

  // R3
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    (full && wr_en) |=> $stable(wbin));

  // R4
  no_underflow_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (empty && rd_en) |=> $stable(rbin));

  // R1
  reset_empty_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    $rose(rrst_n) |-> empty);
endmodule

bind dual_clock_fifo dcf_checker #(.PW(ADDR_W + 1)) u_chk (
  .wclk(wclk), .rclk(rclk), .wrst_n(wrst_n), .rrst_n(rrst_n),
  .wr_en(wr_en), .rd_en(rd_en), .full(full), .empty(empty),
  .wgray(wgray), .rgray(rgray), .wbin(wbin), .rbin(rbin)
);

// File: tb/dual_clock_fifo_test.sv
module dual_clock_fifo_test;
  localparam int AW     = 3;
  localparam int DW     = 8;
  localparam int DEPTH  = 1 << AW;
  localparam int WPER   = 10;
  localparam int RPER   = 17;
  localparam int STREAM = 200;

  logic wclk = 1'b0, rclk = 1'b0;
  logic wrst_n = 1'b0, rrst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic full, empty;

  int checks = 0, fails = 0;
  logic [DW-1:0] model [$];
  int next_val = 0;

  always #(WPER/2) wclk = ~wclk;
  always #(RPER/2) rclk = ~rclk;

  dual_clock_fifo #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rd_data(rd_data), .empty(empty)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One write attempt; the model is updated from the flag seen before the edge.
  task automatic put(input logic [DW-1:0] d, output bit took);
    @(negedge wclk);
    wr_en = 1'b1;
    wr_data = d;
    took = !full;
    if (took) begin
      check(model.size() < DEPTH, "R3 overflow", model.size(), DEPTH - 1);
      model.push_back(d);
    end
    @(posedge wclk);
    #1 wr_en = 1'b0;
  endtask

  // One read attempt; head compared before the edge that takes it.
  task automatic take(output bit took);
    @(negedge rclk);
    rd_en = 1'b1;
    took = !empty;
    if (took) begin
      check(model.size() > 0, "R4 underflow", 0, 1);
      if (model.size() > 0) begin
        check(rd_data == model[0], "R2 data", int'(rd_data), int'(model[0]));
        void'(model.pop_front());
      end
    end
    @(posedge rclk);
    #1 rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(posedge rclk);
    repeat (6) @(posedge wclk);
    @(negedge rclk);
    check(empty == (model.size() == 0), "R2 settled empty", int'(empty), int'(model.size() == 0));
    @(negedge wclk);
    check(full == (model.size() == DEPTH), "R2 settled full", int'(full), int'(model.size() == DEPTH));
  endtask

  initial begin
    #(WPER * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    bit took;
    int n;
    #(WPER * 3 + 3);
    // R1: values while reset is held
    check(empty == 1'b1, "R1 empty in reset", int'(empty), 1);
    check(full == 1'b0, "R1 full in reset", int'(full), 0);
    wrst_n = 1'b1;
    rrst_n = 1'b1;
    @(negedge wclk);
    check(full == 1'b0, "R1 full after reset", int'(full), 0);
    @(negedge rclk);
    check(empty == 1'b1, "R1 empty after reset", int'(empty), 1);

    // R4: reads on an empty FIFO are dropped
    repeat (3) begin
      take(took);
      check(!took, "R4 read while empty", int'(took), 0);
    end
    put(8'hA5, took);
    settle();
    take(took);
    check(took, "R4 word after empty reads", int'(took), 1);

    // R5: empty falls within four read edges of a write
    settle();
    put(8'h3C, took);
    n = 0;
    while (empty && n < 8) begin
      @(posedge rclk);
      n++;
      @(negedge rclk);
    end
    check(!empty && n <= 4, "R5 empty release latency", n, 3);
    settle();
    take(took);

    // R6: fill with reads idle
    settle();
    for (int i = 0; i < DEPTH; i++) begin
      put(DW'(8'h40 + i), took);
      @(negedge wclk);
      if (i == DEPTH - 2) check(full == 1'b0, "R6 not full at DEPTH-1", int'(full), 0);
      if (i == DEPTH - 1) check(full == 1'b1, "R6 full at DEPTH", int'(full), 1);
    end
    // R3: extra writes are dropped
    for (int i = 0; i < 3; i++) begin
      put(8'hEE, took);
      check(!took, "R3 write while full", int'(took), 0);
    end
    check(model.size() == DEPTH, "R3 model depth", model.size(), DEPTH);

    // R8: full falls within four write edges of a read
    take(took);
    n = 0;
    while (full && n < 8) begin
      @(posedge wclk);
      n++;
      @(negedge wclk);
    end
    check(!full && n <= 4, "R8 full release latency", n, 3);

    // R7: drain; empty rises with the last read
    settle();
    while (model.size() > 0) begin
      take(took);
      @(negedge rclk);
      if (model.size() == 0) check(empty == 1'b1, "R7 empty on last read", int'(empty), 1);
      else check(empty == 1'b0, "R7 not empty early", int'(empty), 0);
    end

    // R9: both ports active, many wraps
    fork
      begin
        int sent = 0;
        bit ok;
        while (sent < STREAM) begin
          if ($urandom_range(0, 3) != 0) begin
            put(DW'(next_val), ok);
            if (ok) begin sent++; next_val++; end
          end else @(posedge wclk);
        end
      end
      begin
        int got = 0;
        bit ok;
        while (got < STREAM) begin
          if ($urandom_range(0, 2) != 0) begin
            take(ok);
            if (ok) got++;
          end else @(posedge rclk);
        end
      end
    join
    check(model.size() == 0, "R9 stream fully drained", model.size(), 0);
    settle();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule